// File: doc/BRIEF.md
# Panel Column Load Latch and Ladder Control Decoder

This block sits behind the sampling register of a column driver for a thin-film display panel. When the load strobe arrives, the block copies the whole sampled row of 6-bit grayscale codes into a load register. For every output channel it then produces the control word that steers a resistor-ladder digital-to-analog converter. Each word has four parts: a float flag, a reference bank select, a ladder segment index with the tap inside that segment, and a flag that marks codes which land exactly on a reference node.

A polarity input is captured when the load strobe rises. It decides whether odd-numbered outputs take their voltage from the upper bank (V0..V4) and even-numbered outputs from the lower bank (V5..V9), or the other way round. Alternating the polarity from one load to the next gives dot or n-line inversion. All outputs float while the strobe is high and take their new values once it falls. A strobe that stays high for fewer than the required number of cycles raises a one-cycle error pulse, and the copy is still made.

Top module: `ldl_load_drive`

## Requirements
- R1: After reset every channel float flag is 1 and the short-strobe error is 0, and this holds until the first load strobe has completed.
- R2: The first rising clock edge that samples `load_i` high copies `image_i` into the load register (channel i occupies bits [6i+5:6i]). Changes of `image_i` at any other time do not alter the channel outputs.
- R3: Every float flag is 1 after each clock edge that samples `load_i` high. The flags return to 0 at the first edge that samples `load_i` low after a high period.
- R4: `pol_i` is captured only at the first edge that samples `load_i` high. Changes at any other time do not alter the bank selects.
- R5: For channel index i (0-based, output number i+1), `bank_lo_o[i]`=1 selects the lower bank V5..V9 and 0 selects the upper bank V0..V4. With captured polarity 0, even i gives 0 and odd i gives 1. With captured polarity 1, both are inverted.
- R6: `seg_o[2i+1:2i]` is the ladder segment of the code (0 for 00h-0Fh, 1 for 10h-1Fh, 2 for 20h-2Fh, 3 for 30h-3Fh). `tap_o[4i+3:4i]` is the code's offset from the start of that segment, so 3Fh reports segment 3, tap 15, the end of the 15-division segment.
- R7: `node_o[i]` is 1 exactly for the codes 00h, 10h, 20h, 30h and 3Fh, which land on a reference node.
- R8: If the strobe was sampled high on fewer than MIN_LOAD_CYC consecutive edges (default 3), `short_err_o` is 1 for exactly the one cycle after the edge that samples it low. The copy and the polarity capture still take effect. Longer strobes raise no error.
- R9: While the outputs are driven (float flags 0), the segment, tap, node and bank outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data transfer clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load strobe |
| pol_i | input | 1 | Polarity, captured at the strobe's rise |
| image_i | input | N_CH*6 | Sampled row of grayscale codes, channel i at bits [6i+5:6i] |
| hiz_o | output | N_CH | Per-channel float flag |
| bank_lo_o | output | N_CH | Per-channel bank select, 1 = lower bank V5..V9 |
| seg_o | output | N_CH*2 | Per-channel ladder segment index |
| tap_o | output | N_CH*4 | Per-channel tap within the segment |
| node_o | output | N_CH | Per-channel code-on-reference-node flag |
| short_err_o | output | 1 | One-cycle pulse after a too-short strobe |

## Verification
A wrong edge detector in the strobe logic shows up one cycle after the strobe's rise or fall. The symptoms are float flags released while the strobe is still high, a copy of an image that was changed after the first high sample, or a polarity taken from the wrong cycle. A broken high-cycle counter either raises or drops the error pulse in the cycle right after the fall. A corrupted load register or decoder is only visible once the flags drop, as a wrong segment, tap, node or bank on the affected channel, and it stays wrong until the next load. For that reason every channel is compared after each load, and the polarity is alternated so that both bank mappings are seen.

// File: rtl/ldl_pkg.sv
package ldl_pkg;

    localparam int CODE_W   = 6;
    localparam int SEG_W    = 2;
    localparam int TAP_W    = CODE_W - SEG_W;
    localparam int LAST_DIV = 15;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic [SEG_W-1:0] seg;
        logic [TAP_W-1:0] tap;
        logic             node;
    } ladder_sel_t;

    function automatic ladder_sel_t decode_code(code_t c);
        ladder_sel_t r;
        r.seg  = c[CODE_W-1 -: SEG_W];
        r.tap  = c[TAP_W-1:0];
        r.node = (c[TAP_W-1:0] == '0);
        if (c == '1) begin
            r.tap  = TAP_W'(LAST_DIV);
            r.node = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/ldl_ctrl.sv
module ldl_ctrl #(
    parameter int MIN_LOAD_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic pol_i,
    output logic capture_o,
    output logic hiz_o,
    output logic pol_o,
    output logic short_err_o
);

    localparam int CNT_W = $clog2(MIN_LOAD_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_LOAD_CYC);

    typedef struct packed {
        logic             load;
        logic             hiz;
        logic             pol;
        logic             err;
        logic [CNT_W-1:0] cnt;
    } ctrl_t;

    ctrl_t state_d, state_q;
    logic  rise, fall;

    always_comb begin
        rise    = load_i & ~state_q.load;
        fall    = ~load_i & state_q.load;
        state_d = state_q;
        state_d.load = load_i;
        state_d.err  = 1'b0;
        if (rise) begin
            state_d.pol = pol_i;
            state_d.cnt = CNT_W'(1);
            state_d.hiz = 1'b1;
        end else if (load_i) begin
            state_d.hiz = 1'b1;
            if (state_q.cnt < CNT_MIN) begin
                state_d.cnt = state_q.cnt + CNT_W'(1);
            end
        end else if (fall) begin
            state_d.hiz = 1'b0;
            state_d.err = (state_q.cnt < CNT_MIN);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= '0;
            state_q.hiz  <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    assign capture_o   = rise;
    assign hiz_o       = state_q.hiz;
    assign pol_o       = state_q.pol;
    assign short_err_o = state_q.err;

endmodule

// File: rtl/ldl_load_reg.sv
module ldl_load_reg
    import ldl_pkg::*;
#(
    parameter int N_CH = 384
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   capture_i,
    input  logic [N_CH*CODE_W-1:0] image_i,
    output logic [N_CH*CODE_W-1:0] codes_o
);

    typedef struct packed {
        logic [N_CH*CODE_W-1:0] codes;
    } latch_t;

    latch_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (capture_i) begin
            state_d.codes = image_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign codes_o = state_q.codes;

endmodule

// File: rtl/ldl_chan_decode.sv
module ldl_chan_decode
    import ldl_pkg::*;
#(
    parameter int N_CH = 384
) (
    input  logic [N_CH*CODE_W-1:0] codes_i,
    input  logic                   pol_i,
    output logic [N_CH-1:0]        bank_lo_o,
    output logic [N_CH*SEG_W-1:0]  seg_o,
    output logic [N_CH*TAP_W-1:0]  tap_o,
    output logic [N_CH-1:0]        node_o
);

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        ladder_sel_t sel;
        always_comb begin
            sel = decode_code(codes_i[i*CODE_W +: CODE_W]);
        end
        // odd-numbered outputs (even index) follow the polarity directly
        if ((i % 2) == 0) begin : g_odd_out
            assign bank_lo_o[i] = pol_i;
        end else begin : g_even_out
            assign bank_lo_o[i] = ~pol_i;
        end
        assign seg_o[i*SEG_W +: SEG_W] = sel.seg;
        assign tap_o[i*TAP_W +: TAP_W] = sel.tap;
        assign node_o[i]               = sel.node;
    end

endmodule

// File: rtl/ldl_load_drive.sv
module ldl_load_drive
    import ldl_pkg::*;
#(
    parameter int N_CH         = 384,
    parameter int MIN_LOAD_CYC = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_i,
    input  logic                   pol_i,
    input  logic [N_CH*CODE_W-1:0] image_i,
    output logic [N_CH-1:0]        hiz_o,
    output logic [N_CH-1:0]        bank_lo_o,
    output logic [N_CH*SEG_W-1:0]  seg_o,
    output logic [N_CH*TAP_W-1:0]  tap_o,
    output logic [N_CH-1:0]        node_o,
    output logic                   short_err_o
);

    logic                   capture;
    logic                   hiz;
    logic                   pol_lat;
    logic [N_CH*CODE_W-1:0] codes;

    ldl_ctrl #(
        .MIN_LOAD_CYC (MIN_LOAD_CYC)
    ) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .pol_i       (pol_i),
        .capture_o   (capture),
        .hiz_o       (hiz),
        .pol_o       (pol_lat),
        .short_err_o (short_err_o)
    );

    ldl_load_reg #(
        .N_CH (N_CH)
    ) i_load_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture),
        .image_i   (image_i),
        .codes_o   (codes)
    );

    ldl_chan_decode #(
        .N_CH (N_CH)
    ) i_decode (
        .codes_i   (codes),
        .pol_i     (pol_lat),
        .bank_lo_o (bank_lo_o),
        .seg_o     (seg_o),
        .tap_o     (tap_o),
        .node_o    (node_o)
    );

    assign hiz_o = {N_CH{hiz}};

endmodule

// File: rtl/ldl_load_drive_chk.sv
module ldl_load_drive_chk
    import ldl_pkg::*;
#(
    parameter int N_CH = 384
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  load_i,
    input logic                  pol_i,
    input logic [N_CH-1:0]       hiz_o,
    input logic [N_CH-1:0]       bank_lo_o,
    input logic [N_CH*SEG_W-1:0] seg_o,
    input logic [N_CH*TAP_W-1:0] tap_o,
    input logic [N_CH-1:0]       node_o,
    input logic                  short_err_o
);

    assert_float_in_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (&hiz_o));

    assert_release_after_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && $past(load_i)) |=> (hiz_o == '0));

    assert_pol_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !$past(load_i)) |=> (bank_lo_o[0] == $past(pol_i)));

    assert_stable_driven_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((hiz_o == '0) && $past(hiz_o == '0)) |->
        ($stable(seg_o) && $stable(tap_o) && $stable(node_o) && $stable(bank_lo_o)));

    assert_err_after_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        short_err_o |-> (!$past(load_i) && $past(load_i, 2)));

    assert_err_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        short_err_o |=> !short_err_o);

endmodule

bind ldl_load_drive ldl_load_drive_chk #(
    .N_CH (N_CH)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .pol_i       (pol_i),
    .hiz_o       (hiz_o),
    .bank_lo_o   (bank_lo_o),
    .seg_o       (seg_o),
    .tap_o       (tap_o),
    .node_o      (node_o),
    .short_err_o (short_err_o)
);

// File: tb/test_ldl_load_drive.sv
module test_ldl_load_drive;

    localparam int N_CH = 384;
    localparam int MINC = 3;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                load_i = 1'b0;
    logic                pol_i = 1'b0;
    logic [N_CH*6-1:0]   image_i = '0;
    logic [N_CH-1:0]     hiz_o, bank_lo_o, node_o;
    logic [N_CH*2-1:0]   seg_o;
    logic [N_CH*4-1:0]   tap_o;
    logic                short_err_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    int ref_code [N_CH];
    bit ref_pol = 0;

    always #5 clk = ~clk;

    ldl_load_drive #(.N_CH(N_CH), .MIN_LOAD_CYC(MINC)) i_ldl_load_drive (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .pol_i(pol_i), .image_i(image_i),
        .hiz_o(hiz_o), .bank_lo_o(bank_lo_o), .seg_o(seg_o), .tap_o(tap_o),
        .node_o(node_o), .short_err_o(short_err_o)
    );

    task automatic check(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic fill_image(int mul, int off);
        for (int i = 0; i < N_CH; i++) image_i[i*6 +: 6] = 6'((i * mul + off) % 64);
    endtask

    // compares every channel against the requirement model; one check per call
    task automatic check_outputs(string req);
        int bad = 0;
        int exp_seg, exp_tap, exp_node, exp_bank;
        checks++;
        for (int i = 0; i < N_CH; i++) begin
            exp_seg  = ref_code[i] / 16;                   // R6
            exp_tap  = ref_code[i] % 16;                   // R6, 3Fh -> 15
            exp_node = (ref_code[i] % 16 == 0) || (ref_code[i] == 63); // R7
            exp_bank = (i % 2 == 0) ? int'(ref_pol) : int'(!ref_pol);   // R5
            if (bad == 0 && (int'(seg_o[i*2 +: 2]) != exp_seg || int'(tap_o[i*4 +: 4]) != exp_tap ||
                int'(node_o[i]) != exp_node || int'(bank_lo_o[i]) != exp_bank || hiz_o[i] !== 1'b0)) begin
                $display("FAIL %s: ch %0d got seg=%0d tap=%0d node=%0d bank=%0d hiz=%0d expected seg=%0d tap=%0d node=%0d bank=%0d hiz=0",
                    req, i, seg_o[i*2 +: 2], tap_o[i*4 +: 4], node_o[i], bank_lo_o[i], hiz_o[i],
                    exp_seg, exp_tap, exp_node, exp_bank);
                bad++;
            end
        end
        if (bad != 0) errors++;
    endtask

    // n_high high samples; optionally disturb image and pol after the first edge
    task automatic do_load(int n_high, bit pol, bit disturb, output bit err_seen);
        int hiz_bad = 0;
        pol_i  = pol;
        load_i = 1'b1;
        for (int i = 0; i < N_CH; i++) ref_code[i] = int'(image_i[i*6 +: 6]);
        ref_pol = pol;
        for (int k = 0; k < n_high; k++) begin
            @(negedge clk);
            if (hiz_o !== '1) hiz_bad++;
            if (disturb) begin
                pol_i = ~pol;
                fill_image(7, 13 + k);
            end
        end
        check("R3 float during load", hiz_bad, 0);
        load_i = 1'b0;
        pol_i  = ~pol;
        @(negedge clk);
        err_seen = short_err_o;
    endtask

    task automatic t_reset;
        check("R1 float after reset", int'(&hiz_o), 1);
        check("R1 no error after reset", int'(short_err_o), 0);
        fill_image(3, 1);
        repeat (4) @(negedge clk);
        check("R1 float held before first load", int'(&hiz_o), 1);
    endtask

    task automatic t_basic;
        bit e;
        fill_image(5, 0);
        do_load(3, 1'b0, 1'b0, e);
        check("R8 no error for minimum strobe", int'(e), 0);
        check_outputs("R2 R5 R6 R7 copy and decode, pol 0");
        @(negedge clk);
        check("R8 no later error", int'(short_err_o), 0);
    endtask

    task automatic t_pol_swap;
        bit e;
        fill_image(11, 3);
        do_load(4, 1'b1, 1'b0, e);
        check_outputs("R5 banks swapped, pol 1");
        fill_image(1, 0);
        do_load(5, 1'b0, 1'b0, e);
        check("R8 no error for long strobe", int'(e), 0);
        check_outputs("R5 R6 ramp, pol 0");
    endtask

    task automatic t_ignore;
        bit e;
        fill_image(9, 40);
        pol_i = ~ref_pol;
        repeat (5) @(negedge clk);
        check_outputs("R2 R4 R9 idle changes ignored");
        fill_image(13, 2);
        do_load(3, 1'b1, 1'b1, e);
        check_outputs("R2 R4 changes after first high edge ignored");
    endtask

    task automatic t_corner;
        bit e;
        int c[10] = '{0, 16, 32, 48, 63, 15, 31, 47, 1, 62};
        for (int i = 0; i < N_CH; i++) image_i[i*6 +: 6] = 6'(c[i % 10]);
        do_load(3, 1'b0, 1'b0, e);
        check_outputs("R6 R7 node and end codes");
        check("R6 3Fh segment", int'(seg_o[4*2 +: 2]), 3);
        check("R6 3Fh end tap", int'(tap_o[4*4 +: 4]), 15);
        check("R7 2Fh not a node", int'(node_o[7]), 0);
    endtask

    task automatic t_short;
        bit e;
        fill_image(17, 5);
        do_load(2, 1'b1, 1'b0, e);
        check("R8 error after two-cycle strobe", int'(e), 1);
        check_outputs("R8 copy done despite short strobe");
        @(negedge clk);
        check("R8 error lasts one cycle", int'(short_err_o), 0);
        fill_image(19, 9);
        do_load(1, 1'b0, 1'b0, e);
        check("R8 error after one-cycle strobe", int'(e), 1);
        check_outputs("R8 R4 copy and polarity after one-cycle strobe");
        @(negedge clk);
        check("R8 pulse cleared", int'(short_err_o), 0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_pol_swap();
        t_ignore();
        t_corner();
        t_short();
        repeat (3) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule